// File: doc/BRIEF.md
# Video Field Buffer Address Pointer

This block produces the addresses for one serial port of a field memory that holds one video field. On every clock it moves a bit address along the current scan line. At the end of a line it moves a line address through the field. A field has 260 to 263 lines, and the line count is chosen by a small code. The storage array, the data registers and refresh are built elsewhere. They read `bit_addr` and `line_addr` from this block.

The block has two modes. In delay-line (synchronous) mode, a trim code shortens the last line of the field so that the total delay can be tuned one sample at a time. In independent (asynchronous) mode every line is 910 samples long, and several controls become active: counted line jumps, a line hold, and a one-clock carry at the last sample of a line. Both modes accept a pointer clear and a forced end-of-line.

Top module: `fbp_addr_gen`

## Requirements
- R1: While `rst_n` is low, `bit_addr`, `line_addr` and `carry` are 0, and the previously sampled mode is taken as delay-line (0).
- R2: On each rising clock edge with no restart and no end-of-line, `bit_addr` increases by one. This happens regardless of any data enable. When `bit_addr` is at the last address of its line, the next edge sets it to 0 and moves the line per R7/R8.
- R3: The lines per field are 260 + `field_code` (00→260, 01→261, 10→262, 11→263). The maximum line number is one less. Advancing past the maximum line gives line 0.
- R4: In delay-line mode (`async_mode`=0, as sampled on the previous edge), the line whose number equals the maximum line is 895 + `last_code` samples long for codes 1..15. Code 0 is treated as 15. All other lines, and every line in independent mode, are 910 samples long (last address 909).
- R5: `clr_n` sampled low sets both addresses to 0 and discards any pending jumps and any hold. Clear takes priority over line reset.
- R6: `lrst_n` sampled low forces an end-of-line: the next address is bit 0 of the line chosen by R7/R8. A line reset sampled on the edge right after an edge that sampled `clr_n` low is ignored, and counting continues from address 0.
- R7: In independent mode, a `jump` sample of 1 counts one pending jump when the previous sample was 0; a level held high counts once. At an end-of-line on line n with x pending jumps, the new line is n+1+x, or 0 if that exceeds the maximum line. A jump counted on the end-of-line edge itself applies to the following line. The pending count saturates at 15.
- R8: In independent mode, `hold` sampled at 1 arms a hold. At the next end-of-line, whether natural or forced, the line address stays unchanged and pending jumps are discarded. The hold then clears, unless `hold` is sampled at 1 on that same edge.
- R9: `carry` is 1 exactly while `bit_addr` is 909 in independent mode. In delay-line mode it stays 0.
- R10: An edge on which `async_mode` differs from its value on the previous edge sets both addresses to 0 and clears pending jumps and hold.
- R11: In delay-line mode `jump` and `hold` have no effect on the addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| async_mode | input | 1 | 1 = independent mode, 0 = delay-line mode |
| clr_n | input | 1 | Active-low pointer clear |
| lrst_n | input | 1 | Active-low forced end-of-line |
| jump | input | 1 | Line jump request, counted on low-to-high |
| hold | input | 1 | Line hold request |
| field_code | input | 2 | Lines per field = 260 + code |
| last_code | input | 4 | Last-line trim in delay-line mode |
| bit_addr | output | 10 | Sample address within the line |
| line_addr | output | 9 | Scan line address |
| carry | output | 1 | High while the bit address is 909 in independent mode |

## Verification
On every cycle, the embedded properties check four things: single-step bit counting, clear and mode-change restarts, the hold keeping the line, and jumps counted once per rising level. They also check that the line reset is ignored after a clear and that the carry stays aligned with address 909. Only the bench scenarios can show the arithmetic of the field: the n+1+x jump target and its wrap, the 260–263 line wrap, the trimmed last line in delay-line mode, and how these interact under random mixes of clear, reset, jump, hold and mode changes. These are compared every cycle against a model built from the requirements.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
    // What the pointer does on a given clock edge
    typedef enum logic [1:0] {
        STEP_RUN     = 2'd0,  // plain increment
        STEP_EOL     = 2'd1,  // end of line, natural or forced
        STEP_RESTART = 2'd2   // clear or mode change
    } step_e;
endpackage

// File: rtl/fbp_limits.sv
module fbp_limits #(
    parameter int LINE_BITS = 910,
    parameter int MIN_LINES = 260,
    parameter int FLEN_W    = 2,
    parameter int TRIM_W    = 4,
    parameter int BIT_W     = 10,
    parameter int LINE_W    = 9
) (
    input  logic              sync_sel,
    input  logic [LINE_W-1:0] line_q,
    input  logic [FLEN_W-1:0] field_code,
    input  logic [TRIM_W-1:0] last_code,
    output logic [LINE_W-1:0] max_line,
    output logic [BIT_W-1:0]  last_bit
);
    localparam int TRIM_MAX  = (1 << TRIM_W) - 1;
    localparam int TRIM_BASE = LINE_BITS - TRIM_MAX - 1;

    logic [TRIM_W-1:0] trim;
    logic [BIT_W-1:0]  trim_bit;

    always_comb begin
        max_line = LINE_W'(MIN_LINES - 1) + LINE_W'(field_code);
        trim     = (last_code == '0) ? TRIM_W'(TRIM_MAX) : last_code;
        trim_bit = BIT_W'(TRIM_BASE) + BIT_W'(trim);
        if (sync_sel && (line_q == max_line)) begin
            last_bit = trim_bit;
        end else begin
            last_bit = BIT_W'(LINE_BITS - 1);
        end
    end
endmodule

// File: rtl/fbp_jump_count.sv
module fbp_jump_count #(
    parameter int JUMP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              kill,
    input  logic              consume,
    input  logic              jump_in,
    output logic [JUMP_W-1:0] pending
);
    localparam logic [JUMP_W-1:0] CNT_MAX = '1;

    logic [JUMP_W-1:0] cnt_d, cnt_q;
    logic              prev_d, prev_q;
    logic              rise;

    always_comb begin
        rise   = en && jump_in && !prev_q;
        prev_d = jump_in;
        cnt_d  = cnt_q;
        if (kill) begin
            cnt_d = '0;
        end else if (consume) begin
            cnt_d = rise ? JUMP_W'(1) : '0;
        end else if (rise && (cnt_q != CNT_MAX)) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            prev_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            prev_q <= prev_d;
        end
    end

    assign pending = cnt_q;

    // R7: a level held high never adds a second jump
    a_r7_level_once: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !kill && !consume && jump_in && prev_q) |=> (cnt_q == $past(cnt_q)));
    // R7: the count only rises through a sampled rising level
    a_r7_rise_only: assert property (@(posedge clk) disable iff (!rst_n)
        (!kill && !consume && !(jump_in && !prev_q)) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/fbp_addr_gen.sv
module fbp_addr_gen #(
    parameter  int LINE_BITS = 910,
    parameter  int MIN_LINES = 260,
    parameter  int FLEN_W    = 2,
    parameter  int TRIM_W    = 4,
    parameter  int JUMP_W    = 4,
    localparam int MAX_LINES = MIN_LINES + (1 << FLEN_W) - 1,
    localparam int BIT_W     = $clog2(LINE_BITS),
    localparam int LINE_W    = $clog2(MAX_LINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              async_mode,
    input  logic              clr_n,
    input  logic              lrst_n,
    input  logic              jump,
    input  logic              hold,
    input  logic [FLEN_W-1:0] field_code,
    input  logic [TRIM_W-1:0] last_code,
    output logic [BIT_W-1:0]  bit_addr,
    output logic [LINE_W-1:0] line_addr,
    output logic              carry
);
    import fbp_pkg::*;

    localparam int SUM_W = LINE_W + 1;

    typedef struct packed {
        logic [BIT_W-1:0]  bit_a;
        logic [LINE_W-1:0] line_a;
        logic              hold_arm;
        logic              mode;
        logic              clr_prev;
        logic              carry;
    } state_t;

    state_t            st_d, st_q;
    step_e             step;
    logic [LINE_W-1:0] max_line;
    logic [BIT_W-1:0]  last_bit;
    logic [JUMP_W-1:0] pending;
    logic [SUM_W-1:0]  jump_sum;
    logic [LINE_W-1:0] adv_line;
    logic              mode_chg;
    logic              lrst_live;
    logic              at_end;

    fbp_limits #(
        .LINE_BITS (LINE_BITS),
        .MIN_LINES (MIN_LINES),
        .FLEN_W    (FLEN_W),
        .TRIM_W    (TRIM_W),
        .BIT_W     (BIT_W),
        .LINE_W    (LINE_W)
    ) u_limits (
        .sync_sel   (!st_q.mode),
        .line_q     (st_q.line_a),
        .field_code (field_code),
        .last_code  (last_code),
        .max_line   (max_line),
        .last_bit   (last_bit)
    );

    fbp_jump_count #(
        .JUMP_W (JUMP_W)
    ) u_jumps (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (st_q.mode),
        .kill    (step == STEP_RESTART),
        .consume (step == STEP_EOL),
        .jump_in (jump),
        .pending (pending)
    );

    always_comb begin
        mode_chg  = (async_mode != st_q.mode);
        lrst_live = !lrst_n && !st_q.clr_prev;
        at_end    = (st_q.bit_a == last_bit);

        if (mode_chg || !clr_n) begin
            step = STEP_RESTART;
        end else if (lrst_live || at_end) begin
            step = STEP_EOL;
        end else begin
            step = STEP_RUN;
        end

        jump_sum = SUM_W'(st_q.line_a) + SUM_W'(1) + SUM_W'(pending);
        adv_line = (jump_sum > SUM_W'(max_line)) ? '0 : jump_sum[LINE_W-1:0];

        st_d          = st_q;
        st_d.mode     = async_mode;
        st_d.clr_prev = !clr_n;

        case (step)
            STEP_RESTART: begin
                st_d.bit_a    = '0;
                st_d.line_a   = '0;
                st_d.hold_arm = 1'b0;
            end
            STEP_EOL: begin
                st_d.bit_a    = '0;
                st_d.line_a   = st_q.hold_arm ? st_q.line_a : adv_line;
                st_d.hold_arm = hold && st_q.mode;
            end
            default: begin
                st_d.bit_a    = st_q.bit_a + 1'b1;
                st_d.hold_arm = st_q.hold_arm || (hold && st_q.mode);
            end
        endcase

        st_d.carry = st_d.mode && (st_d.bit_a == BIT_W'(LINE_BITS - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bit_addr  = st_q.bit_a;
    assign line_addr = st_q.line_a;
    assign carry     = st_q.carry;

    // R2: a plain edge steps the bit address by exactly one
    a_r2_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_RUN) |=> (st_q.bit_a == $past(st_q.bit_a) + 1'b1));
    // R2: the bit address never leaves the line
    a_r2_bit_range: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.bit_a < BIT_W'(LINE_BITS));
    // R5: clear lands on line 0, bit 0
    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (st_q.bit_a == '0 && st_q.line_a == '0));
    // R6: line reset right after a clear is ignored
    a_r6_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.clr_prev && clr_n && !mode_chg && !at_end)
        |=> (st_q.bit_a == $past(st_q.bit_a) + 1'b1));
    // R8: an armed hold keeps the line across the end of line
    a_r8_hold_line: assert property (@(posedge clk) disable iff (!rst_n)
        (step == STEP_EOL && st_q.hold_arm) |=> (st_q.line_a == $past(st_q.line_a)));
    // R9: carry follows address 909 in independent mode
    a_r9_carry: assert property (@(posedge clk) disable iff (!rst_n)
        carry == (st_q.mode && st_q.bit_a == BIT_W'(LINE_BITS - 1)));
    // R10: a mode change restarts both addresses
    a_r10_mode: assert property (@(posedge clk) disable iff (!rst_n)
        mode_chg |=> (st_q.bit_a == '0 && st_q.line_a == '0));
endmodule

// File: tb/tb_fbp_addr_gen.sv
module tb_fbp_addr_gen;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       async_mode, clr_n, lrst_n, jump_i, hold_i;
    logic [1:0] field_code;
    logic [3:0] last_code;
    logic [9:0] bit_addr;
    logic [8:0] line_addr;
    logic       carry;

    int    checks = 0;
    int    errors = 0;
    bit    done   = 0;
    string tag    = "R1";

    // model state, built from the requirements
    int m_bit = 0, m_line = 0, m_pend = 0;
    bit m_prev = 0, m_hold = 0, m_mode = 0, m_clrp = 0, m_carry = 0;

    always #5 clk = ~clk;

    fbp_addr_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_mode (async_mode),
        .clr_n      (clr_n),
        .lrst_n     (lrst_n),
        .jump       (jump_i),
        .hold       (hold_i),
        .field_code (field_code),
        .last_code  (last_code),
        .bit_addr   (bit_addr),
        .line_addr  (line_addr),
        .carry      (carry)
    );

    function automatic int max_line_of(input int code);
        return 259 + code;
    endfunction

    function automatic int last_bit_of(input bit mode, input int line, input int fc, input int lc);
        int trim;
        trim = (lc == 0) ? 15 : lc;
        if (!mode && line == max_line_of(fc)) return 894 + trim;
        return 909;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_bit = 0; m_line = 0; m_pend = 0; m_prev = 0;
            m_hold = 0; m_mode = 0; m_clrp = 0; m_carry = 0;
        end else begin
            int  mx, lb, sum;
            bit  chg, rise, eol;
            mx   = max_line_of(field_code);
            lb   = last_bit_of(m_mode, m_line, field_code, last_code);
            chg  = (async_mode != m_mode);
            rise = m_mode && jump_i && !m_prev;
            eol  = (!lrst_n && !m_clrp) || (m_bit == lb);
            if (chg || !clr_n) begin
                m_bit = 0; m_line = 0; m_hold = 0; m_pend = 0;
            end else if (eol) begin
                sum   = m_line + 1 + m_pend;
                m_bit = 0;
                if (!m_hold) m_line = (sum > mx) ? 0 : sum;
                m_pend = rise ? 1 : 0;
                m_hold = hold_i && m_mode;
            end else begin
                m_bit = m_bit + 1;
                if (rise && m_pend < 15) m_pend = m_pend + 1;
                m_hold = m_hold || (hold_i && m_mode);
            end
            m_prev  = jump_i;
            m_mode  = async_mode;
            m_clrp  = !clr_n;
            m_carry = m_mode && (m_bit == 909);
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic compare_model();
        checks++;
        if (bit_addr != m_bit[9:0] || line_addr != m_line[8:0] || carry != m_carry) begin
            errors++;
            $display("FAIL %s actual bit %0d line %0d carry %0d expected bit %0d line %0d carry %0d",
                     tag, bit_addr, line_addr, carry, m_bit, m_line, m_carry);
        end
    endtask

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare_model();
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; async_mode = 0; clr_n = 1; lrst_n = 1; jump_i = 0; hold_i = 0;
        field_code = 2'd3; last_code = 4'd15;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 bit", bit_addr, 0); chk("R1 line", line_addr, 0); chk("R1 carry", carry, 0);
        rst_n = 1;

        // R2: plain counting in delay-line mode
        tag = "R2"; tick(5);
        chk("R2 bit", bit_addr, 5);

        // R10: mode change restarts
        tag = "R10"; async_mode = 1; tick();
        chk("R10 bit", bit_addr, 0);

        // R9: carry at 909, then R2 line advance
        tag = "R9"; tick(909);
        chk("R9 bit", bit_addr, 909); chk("R9 carry", carry, 1);
        tag = "R2"; tick();
        chk("R2 wrap bit", bit_addr, 0); chk("R2 line", line_addr, 1); chk("R9 carry low", carry, 0);

        // R7: two counted jumps, one held level, then forced end-of-line
        tag = "R7";
        jump_i = 1; tick(); jump_i = 0; tick(); jump_i = 1; tick(2); jump_i = 0;
        lrst_n = 0; tick(); lrst_n = 1;
        chk("R7 line n+1+x", line_addr, 4); chk("R6 bit", bit_addr, 0);

        // R8: hold keeps the line once
        tag = "R8";
        hold_i = 1; tick(); hold_i = 0;
        lrst_n = 0; tick();
        chk("R8 held line", line_addr, 4);
        tick(); lrst_n = 1;
        chk("R8 released", line_addr, 5);

        // R5 priority and R6 ignored after clear
        tag = "R5"; clr_n = 0; lrst_n = 0; tick();
        chk("R5 bit", bit_addr, 0); chk("R5 line", line_addr, 0);
        tag = "R6"; clr_n = 1; tick();
        chk("R6 ignored bit", bit_addr, 1); chk("R6 ignored line", line_addr, 0);
        tick(); lrst_n = 1;
        chk("R6 reset line", line_addr, 1);

        // R3: 263-line field wrap, and R7 jump wrap
        tag = "R3"; lrst_n = 0; tick(261); lrst_n = 1;
        chk("R3 last line", line_addr, 262);
        lrst_n = 0; tick(); lrst_n = 1;
        chk("R3 wrap", line_addr, 0);
        lrst_n = 0; tick(261); lrst_n = 1;
        tag = "R7"; jump_i = 1; tick(); jump_i = 0; tick();
        lrst_n = 0; tick(); lrst_n = 1;
        chk("R7 jump wrap", line_addr, 0);

        // R4: trimmed last line in delay-line mode, 260 lines
        tag = "R4"; async_mode = 0; tick();
        field_code = 2'd0; last_code = 4'd1;
        lrst_n = 0; tick(259); lrst_n = 1;
        chk("R4 line", line_addr, 259);
        tick(895);
        chk("R4 bit", bit_addr, 895);
        tick();
        chk("R4 short wrap bit", bit_addr, 0); chk("R4 short wrap line", line_addr, 0);
        last_code = 4'd0;
        lrst_n = 0; tick(259); lrst_n = 1;
        tick(909);
        chk("R4 code0 bit", bit_addr, 909); chk("R9 sync carry", carry, 0);
        tick();
        chk("R4 code0 wrap", line_addr, 0);

        // R11: jump and hold ignored in delay-line mode
        tag = "R11";
        jump_i = 1; tick(); jump_i = 0; hold_i = 1; tick(); hold_i = 0;
        lrst_n = 0; tick(); lrst_n = 1;
        chk("R11 line", line_addr, 1);

        // random mix against the model
        tag = "R7 R8 random";
        void'($urandom(32'd20240611));
        for (int i = 0; i < 40000; i++) begin
            clr_n  = ($urandom_range(199) != 0);
            lrst_n = ($urandom_range(39) != 0);
            if ($urandom_range(7) == 0) jump_i = ~jump_i;
            hold_i = ($urandom_range(29) == 0);
            if ($urandom_range(2999) == 0) async_mode = ~async_mode;
            if ($urandom_range(499) == 0) field_code = 2'($urandom_range(3));
            if ($urandom_range(499) == 0) last_code = 4'($urandom_range(15));
            tick();
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule